// File: doc/BRIEF.md
# Phase-Frequency Detector Core with Turbo Acquisition

This block is the digital heart of a PLL phase comparator. It receives two divided edge streams, one from the reference divider and one from the oscillator divider, both synchronous to the block clock. From them it produces three-state pump commands: pump up, pump down, or neither. A polarity input swaps the meaning of up and down, so the block can serve an oscillator whose frequency rises with tune voltage and one whose frequency falls with it.

The charge-pump magnitude leaves the block as a 2-bit code taken from one of two stored codes, chosen by a set-select line. The code values 00, 01, 10 and 11 stand for roughly 150, 210, 300 and 425 µA of locked pump current. A turbo flag tells the pump to use a large fixed current of about 2100 µA instead. A start-acquisition pulse arms that flag when turbo is enabled. The flag drops by itself when the loop reaches lock, which returns the pump to the programmed code.

Lock is declared after a run of consecutive comparison cycles in which the one-sided pulse stays narrow. A single wide pulse clears lock as soon as it grows too wide.

Top module: `pfd_turbo_core`

## Requirements
- R1: After reset, pumpUp, pumpDn, lock and turboActive are all 0.
- R2: With pumpPol = 1, a reference rising edge leading the oscillator rising edge by d clock cycles drives pumpUp high for d+1 cycles and pumpDn high for 1 cycle. An oscillator lead does the reverse.
- R3: With pumpPol = 0, the roles are swapped: a reference lead of d cycles drives pumpDn for d+1 cycles and pumpUp for 1 cycle. An oscillator lead drives pumpUp for d+1 cycles.
- R4: Once pumpUp and pumpDn are both high, both are low in the next cycle. Coincident edges (d = 0) give one cycle of each.
- R5: curCode equals codeA when setSel = 1 and codeB when setSel = 0. It changes in the same cycle as its inputs, and turboActive does not affect it.
- R6: lock rises once 16 consecutive comparison cycles have completed, each with a one-sided width d of at most 3 cycles (NARROW_MAX). A width of exactly 3 still counts as narrow.
- R7: A one-sided pulse whose width reaches 4 cycles clears lock at its fourth one-sided cycle, before the lagging edge arrives. The run of narrow cycles then starts again from zero.
- R8: An acqStart pulse clears lock in the next cycle. It also loads turboActive with turboEn, so turbo is armed only when turboEn = 1.
- R9: turboActive falls on the same clock edge on which lock rises. lock and turboActive are never high together.
- R10: When turboEn is 0, turboActive is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| refDiv | input | 1 | Divided reference stream; rising edges are compared |
| vcoDiv | input | 1 | Divided oscillator stream; rising edges are compared |
| pumpPol | input | 1 | 1: reference lead drives up; 0: oscillator lead drives up |
| turboEn | input | 1 | Permits turbo acquisition |
| acqStart | input | 1 | One-cycle pulse that starts a new acquisition |
| setSel | input | 1 | 1 selects codeA, 0 selects codeB |
| codeA | input | 2 | First stored current code |
| codeB | input | 2 | Second stored current code |
| pumpUp | output | 1 | Source-current command |
| pumpDn | output | 1 | Sink-current command |
| curCode | output | 2 | Selected locked-current code |
| turboActive | output | 1 | Pump should use the large acquisition current |
| lock | output | 1 | Loop is locked |

## Verification
The hardest state to reach from the ports is a wide pulse that arrives while the block is already locked. The bench must show that lock drops part-way through that pulse, not when the comparison ends. To get there, it first builds lock with sixteen narrow comparisons. It then sends a reference edge whose oscillator partner is held back six cycles, and samples lock on the fifth cycle, while the lagging edge has still not come. The boundary between narrow and wide is approached from both sides: a three-cycle lead must keep lock, and a four-cycle lead must drop it.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Strobes from the datapath to the lock/turbo control
  typedef struct packed {
    logic narrow;  // comparison completed with an acceptable one-sided width
    logic wide;    // one-sided pulse has just grown past the limit
  } pfdStrobe_t;

endpackage

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int NARROW_MAX = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refDiv,
  input  logic       vcoDiv,
  input  logic       pumpPol,
  output logic       pumpUp,
  output logic       pumpDn,
  output pfdStrobe_t strobe
);

  localparam int WCW = $clog2(NARROW_MAX + 2);
  localparam logic [WCW-1:0] W_LIMIT = WCW'(NARROW_MAX);

  logic refPrev, vcoPrev;
  logic refLatch, vcoLatch;
  logic [WCW-1:0] widthCnt;

  logic refEdge, vcoEdge, bothOn, oneOn;

  assign refEdge = refDiv & ~refPrev;
  assign vcoEdge = vcoDiv & ~vcoPrev;
  assign bothOn  = refLatch & vcoLatch;
  assign oneOn   = refLatch ^ vcoLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev  <= 1'b0;
      vcoPrev  <= 1'b0;
      refLatch <= 1'b0;
      vcoLatch <= 1'b0;
    end else begin
      refPrev  <= refDiv;
      vcoPrev  <= vcoDiv;
      // both latched: clear together (edges in this cycle are dropped)
      refLatch <= (refLatch | refEdge) & ~bothOn;
      vcoLatch <= (vcoLatch | vcoEdge) & ~bothOn;
    end
  end

  // width of the one-sided part of the current comparison, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthCnt <= '0;
    end else if (bothOn) begin
      widthCnt <= '0;
    end else if (oneOn && widthCnt <= W_LIMIT) begin
      widthCnt <= widthCnt + 1'b1;
    end
  end

  assign strobe.narrow = bothOn & (widthCnt <= W_LIMIT);
  assign strobe.wide   = oneOn & (widthCnt == W_LIMIT);

  // polarity swap between the two latches and the pump commands
  assign pumpUp = pumpPol ? refLatch : vcoLatch;
  assign pumpDn = pumpPol ? vcoLatch : refLatch;

endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl
  import pfd_pkg::*;
#(
  parameter int LOCK_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  pfdStrobe_t strobe,
  input  logic       turboEn,
  input  logic       acqStart,
  input  logic       setSel,
  input  logic [1:0] codeA,
  input  logic [1:0] codeB,
  output logic [1:0] curCode,
  output logic       turboActive,
  output logic       lock
);

  localparam int LCW = $clog2(LOCK_CYCLES + 1);
  localparam logic [LCW-1:0] L_FULL = LCW'(LOCK_CYCLES);
  localparam logic [LCW-1:0] L_LAST = LCW'(LOCK_CYCLES - 1);

  logic [LCW-1:0] lockCnt;
  logic lockHit;

  assign lockHit = strobe.narrow && (lockCnt == L_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockCnt <= '0;
    end else if (acqStart || strobe.wide) begin
      lockCnt <= '0;
    end else if (strobe.narrow && lockCnt != L_FULL) begin
      lockCnt <= lockCnt + 1'b1;
    end
  end

  assign lock = (lockCnt == L_FULL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      turboActive <= 1'b0;
    end else if (acqStart) begin
      turboActive <= turboEn;
    end else if (!turboEn || lockHit) begin
      turboActive <= 1'b0;
    end
  end

  assign curCode = setSel ? codeA : codeB;

endmodule

// File: rtl/pfd_turbo_core.sv
module pfd_turbo_core
  import pfd_pkg::*;
#(
  parameter int NARROW_MAX  = 3,
  parameter int LOCK_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refDiv,
  input  logic       vcoDiv,
  input  logic       pumpPol,
  input  logic       turboEn,
  input  logic       acqStart,
  input  logic       setSel,
  input  logic [1:0] codeA,
  input  logic [1:0] codeB,
  output logic       pumpUp,
  output logic       pumpDn,
  output logic [1:0] curCode,
  output logic       turboActive,
  output logic       lock
);

  pfdStrobe_t strobe;

  pfd_datapath #(.NARROW_MAX(NARROW_MAX)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .refDiv (refDiv),
    .vcoDiv (vcoDiv),
    .pumpPol(pumpPol),
    .pumpUp (pumpUp),
    .pumpDn (pumpDn),
    .strobe (strobe)
  );

  pfd_lock_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .turboEn    (turboEn),
    .acqStart   (acqStart),
    .setSel     (setSel),
    .codeA      (codeA),
    .codeB      (codeB),
    .curCode    (curCode),
    .turboActive(turboActive),
    .lock       (lock)
  );

endmodule

// File: rtl/pfd_turbo_core_chk.sv
module pfd_turbo_core_chk (
  input logic clk,
  input logic rstN,
  input logic pumpUp,
  input logic pumpDn,
  input logic turboEn,
  input logic acqStart,
  input logic turboActive,
  input logic lock
);

  // R4
  both_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pumpUp && pumpDn) |=> (!pumpUp && !pumpDn));

  // R9
  lock_turbo_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    lock |-> !turboActive);

  // R8
  turbo_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(turboActive) |-> ($past(acqStart) && $past(turboEn)));

  // R8
  acq_unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    acqStart |=> !lock);

  // R10
  turbo_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !turboEn |=> !turboActive);

endmodule

bind pfd_turbo_core pfd_turbo_core_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pumpUp     (pumpUp),
  .pumpDn     (pumpDn),
  .turboEn    (turboEn),
  .acqStart   (acqStart),
  .turboActive(turboActive),
  .lock       (lock)
);

// File: tb/test_pfd_turbo_core.sv
module test_pfd_turbo_core;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refDiv = 1'b0, vcoDiv = 1'b0, pumpPol = 1'b1;
  logic turboEn = 1'b0, acqStart = 1'b0, setSel = 1'b1;
  logic [1:0] codeA = 2'b00, codeB = 2'b00;
  logic pumpUp, pumpDn, turboActive, lock;
  logic [1:0] curCode;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pfd_turbo_core i_pfd_turbo_core (
    .clk(clk), .rstN(rstN), .refDiv(refDiv), .vcoDiv(vcoDiv),
    .pumpPol(pumpPol), .turboEn(turboEn), .acqStart(acqStart),
    .setSel(setSel), .codeA(codeA), .codeB(codeB),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .curCode(curCode),
    .turboActive(turboActive), .lock(lock)
  );

  // row: {pol, refFirst, lead[2:0], expUp[3:0], expDn[3:0]}
  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 1'b1, 3'd2, 4'd3, 4'd1},   // R2 reference lead
    {1'b1, 1'b0, 3'd2, 4'd1, 4'd3},   // R2 oscillator lead
    {1'b0, 1'b1, 3'd2, 4'd1, 4'd3},   // R3 reference lead
    {1'b0, 1'b0, 3'd3, 4'd4, 4'd1},   // R3 oscillator lead
    {1'b1, 1'b1, 3'd0, 4'd1, 4'd1},   // R4 coincident edges
    {1'b0, 1'b1, 3'd5, 4'd1, 4'd6}    // R3 long lead
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one comparison: leader edge at step 0, follower at step lead
  task automatic runCmp(input bit refFirst, input int lead,
                        output int nUp, output int nDn, output bit lockAt5);
    nUp = 0; nDn = 0; lockAt5 = 1'b0;
    for (int i = 0; i < lead + 12; i++) begin
      @(negedge clk);
      if (pumpUp) nUp++;
      if (pumpDn) nDn++;
      if (i == 5) lockAt5 = lock;
      refDiv = refFirst ? (i == 0) : (i == lead);
      vcoDiv = refFirst ? (i == lead) : (i == 0);
    end
  endtask

  task automatic pulseAcq(input bit en);
    @(negedge clk);
    turboEn = en;
    acqStart = 1'b1;
    @(negedge clk);
    acqStart = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks + 1, nFails);
    $finish;
  end

  initial begin : main
    int u, d;
    bit l5;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!pumpUp && !pumpDn, "R1 pumps idle", {pumpUp, pumpDn}, 0);
    check(!lock, "R1 lock low", lock, 0);
    check(!turboActive, "R1 turbo low", turboActive, 0);

    // R2 R3 R4 table
    foreach (VEC[k]) begin
      pumpPol = VEC[k][12];
      runCmp(VEC[k][11], int'(VEC[k][10:8]), u, d, l5);
      check(u == int'(VEC[k][7:4]), $sformatf("R2/R3 row %0d up cycles", k), u, int'(VEC[k][7:4]));
      check(d == int'(VEC[k][3:0]), $sformatf("R2/R3 row %0d dn cycles", k), d, int'(VEC[k][3:0]));
    end

    // R5 code selection, codes 00..11 mean 150/210/300/425 uA
    @(negedge clk);
    codeA = 2'b10; codeB = 2'b01; setSel = 1'b1;
    #1 check(curCode == 2'b10, "R5 setSel=1 picks codeA", curCode, 2);
    setSel = 1'b0;
    #1 check(curCode == 2'b01, "R5 setSel=0 picks codeB", curCode, 1);

    // R8 arm turbo, clear lock
    pumpPol = 1'b1;
    pulseAcq(1'b1);
    check(turboActive, "R8 turbo armed", turboActive, 1);
    check(!lock, "R8 lock cleared", lock, 0);
    check(curCode == 2'b01, "R5 code unchanged by turbo", curCode, 1);

    // R6 fifteen narrow cycles: no lock yet
    for (int n = 0; n < 15; n++) runCmp(1'b1, 1, u, d, l5);
    check(!lock, "R6 no lock after 15", lock, 0);
    check(turboActive, "R9 turbo held before lock", turboActive, 1);
    runCmp(1'b1, 1, u, d, l5);
    check(lock, "R6 lock after 16", lock, 1);
    check(!turboActive, "R9 turbo dropped at lock", turboActive, 0);

    // R6 width exactly NARROW_MAX keeps lock
    runCmp(1'b1, 3, u, d, l5);
    check(lock, "R6 width 3 keeps lock", lock, 1);
    // R7 width 4 clears lock
    runCmp(1'b0, 4, u, d, l5);
    check(!lock, "R7 width 4 drops lock", lock, 0);

    // relock, then a wide pulse checked mid-pulse
    for (int n = 0; n < 16; n++) runCmp(1'b0, 0, u, d, l5);
    check(lock, "R6 relock after 16 coincident", lock, 1);
    runCmp(1'b1, 6, u, d, l5);
    check(!l5, "R7 lock cleared before lagging edge", l5, 0);
    check(!lock, "R7 lock low after wide cycle", lock, 0);

    // R7 count restarted: 15 narrow after wide are not enough
    for (int n = 0; n < 15; n++) runCmp(1'b1, 2, u, d, l5);
    check(!lock, "R7 count restarted", lock, 0);
    runCmp(1'b1, 2, u, d, l5);
    check(lock, "R7 relock at 16th", lock, 1);
    check(!turboActive, "R9 turbo stays off without acqStart", turboActive, 0);

    // R8 acqStart with turbo disabled
    pulseAcq(1'b0);
    check(!turboActive, "R8 turboEn=0 keeps turbo off", turboActive, 0);
    check(!lock, "R8 acqStart clears lock", lock, 0);

    // R10 turboEn dropped while armed
    pulseAcq(1'b1);
    check(turboActive, "R10 turbo armed", turboActive, 1);
    turboEn = 1'b0;
    @(negedge clk);
    check(!turboActive, "R10 turbo off after turboEn low", turboActive, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule